// File: doc/BRIEF.md
# Two-Vector Message-Signaled Interrupt Generator

This block sits beside a messaging unit and delivers its outbound interrupt events to the host. It watches three outbound sources: the post queue, the doorbell and the message source. While message signaling is enabled, each event becomes a single-beat memory write toward the host. The write carries a programmed 64-bit address and a programmed data word, and it goes to a simple request/acknowledge bus master. While message signaling is disabled, the block drives an active-low wired interrupt line instead.

Configuration software programs the capability registers over a small register bus: control, lower address, upper address and data. The control register always reports that the block can generate two distinct messages and that it accepts a 64-bit address. Software grants one or two messages. With two granted, the post queue has a vector of its own and the doorbell and message sources share the second vector. Hardware marks the vector in data bit 0. With one granted, every source sends the unmodified data word. A nonzero upper address flags the write as a dual-address-cycle transfer.

The issue path is a two-state machine. IDLE waits for an enabled pending vector. The transition IDLE->SEND captures the address, data and dual-address flag. SEND holds the request. The transition SEND->IDLE is taken on acknowledge and clears the served vector's pending flag.

Top module: `msi_irq_gen`

## Requirements
- R1: Register 0 (control) reads bit 0 = message enable, bits 6:4 = granted-messages field (read/write), bits 3:1 = 3'b001 (two messages capable, read-only) and bit 7 = 1 (64-bit address capable, read-only). After reset it reads 32'h0000_0082.
- R2: Register 1 (lower address), register 2 (upper address) and register 3 (data, bits 15:0 stored, upper bits read 0) read back what was written. All of them reset to 0.
- R3: A rising edge on a source while messages are enabled produces exactly one write. The write address is {upper, lower}. A source held high produces no further writes.
- R4: When the granted field is 1, hardware replaces data bit 0. Post queue writes carry 0 there, and doorbell or message writes carry 1. Bits 15:1 come from the data register, and write data bits 31:16 are 0.
- R5: When the granted field is 0, every source writes the data register value unmodified.
- R6: Granted values 2 to 7 behave as two messages.
- R7: wr_dac is 1 exactly when the upper address is nonzero.
- R8: wr_req, wr_addr, wr_data and wr_dac stay constant until wr_ack. wr_req falls in the cycle after the acknowledge when nothing else is pending.
- R9: When both vectors are pending, the post queue vector is sent first, and the shared vector follows.
- R10: With messages disabled, irq_n is low while any source is high, and no write is requested. With messages enabled, irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 control, 1 lower address, 2 upper address, 3 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| src_postq | input | 1 | Post queue interrupt source |
| src_doorbell | input | 1 | Doorbell interrupt source |
| src_msg | input | 1 | Message interrupt source |
| wr_req | output | 1 | Message write request |
| wr_ack | input | 1 | Bus master accepts the request |
| wr_addr | output | 64 | Message write address |
| wr_data | output | 32 | Message write data |
| wr_dac | output | 1 | Dual-address-cycle flag |
| irq_n | output | 1 | Active-low wired interrupt |

## Verification
A wrong internal state shows up at the ports within a few cycles. A pending flag that is lost or set twice appears as a missing or extra write request two cycles after the source edge. A vector selection held in the wrong state appears as a wrong data bit 0 or a wrong message order in the first request. An issue machine that leaves SEND early or late shows as a request that drops before the acknowledge or stays high after it. Register state that is lost shows immediately on reg_rdata and on the captured write fields.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int REG_W   = 32;
    localparam int MDATA_W = 16;
    localparam int NUM_VEC = 2;
    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_ADDR_LO = 2'd1,
        REG_ADDR_HI = 2'd2,
        REG_DATA    = 2'd3
    } msi_reg_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } issue_state_e;

    localparam logic [2:0] MMC_TWO = 3'b001;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int DW = MDATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          msi_en,
    output logic          two_vec,
    output logic [RW-1:0] addr_lo,
    output logic [RW-1:0] addr_hi,
    output logic [DW-1:0] msg_data
);
    logic [2:0] mme;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msi_en   <= 1'b0;
            mme      <= 3'd0;
            addr_lo  <= '0;
            addr_hi  <= '0;
            msg_data <= '0;
        end else if (reg_we) begin
            unique case (msi_reg_e'(reg_addr))
                REG_CTRL: begin
                    msi_en <= reg_wdata[0];
                    mme    <= reg_wdata[6:4];
                end
                REG_ADDR_LO: addr_lo  <= reg_wdata;
                REG_ADDR_HI: addr_hi  <= reg_wdata;
                REG_DATA:    msg_data <= reg_wdata[DW-1:0];
            endcase
        end
    end

    assign two_vec = (mme != 3'd0);

    always_comb begin
        reg_rdata = '0;
        unique case (msi_reg_e'(reg_addr))
            REG_CTRL: begin
                reg_rdata[0]   = msi_en;
                reg_rdata[3:1] = MMC_TWO;
                reg_rdata[6:4] = mme;
                reg_rdata[7]   = 1'b1;
            end
            REG_ADDR_LO: reg_rdata = addr_lo;
            REG_ADDR_HI: reg_rdata = addr_hi;
            REG_DATA:    reg_rdata[DW-1:0] = msg_data;
        endcase
    end
endmodule

// File: rtl/msi_pending.sv
module msi_pending
    import msi_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int NV = NUM_VEC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src,
    input  logic          msi_en,
    input  logic [NV-1:0] clr,
    output logic [NV-1:0] pend
);
    logic [NS-1:0] src_q;
    logic [NS-1:0] rise;
    logic [NV-1:0] set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    assign rise = src & ~src_q;

    // vector 0: post queue alone; vector 1: every other source
    assign set[0] = rise[0];
    assign set[1] = |rise[NS-1:1];

    for (genvar v = 0; v < NV; v++) begin : g_vec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pend[v] <= 1'b0;
            else if (!msi_en) pend[v] <= 1'b0;
            else              pend[v] <= set[v] | (pend[v] & ~clr[v]);
        end
    end

    // R3: an edge while enabled always leaves the vector pending
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_en && rise[0]) |=> pend[0]);
endmodule

// File: rtl/msi_issue_fsm.sv
module msi_issue_fsm
    import msi_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int DW = MDATA_W,
    parameter int NV = NUM_VEC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NV-1:0]   pend,
    input  logic            msi_en,
    input  logic            two_vec,
    input  logic [RW-1:0]   addr_lo,
    input  logic [RW-1:0]   addr_hi,
    input  logic [DW-1:0]   msg_data,
    input  logic            wr_ack,
    output logic [NV-1:0]   clr,
    output logic            wr_req,
    output logic [2*RW-1:0] wr_addr,
    output logic [RW-1:0]   wr_data,
    output logic            wr_dac
);
    issue_state_e state, state_nxt;
    logic         sel, sel_nxt;
    logic         any_go;

    assign any_go = msi_en && (|pend);

    always_comb begin
        state_nxt = state;
        sel_nxt   = sel;
        unique case (state)
            ST_IDLE: if (any_go) begin
                state_nxt = ST_SEND;
                sel_nxt   = pend[0] ? 1'b0 : 1'b1;
            end
            ST_SEND: if (wr_ack) state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sel     <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_dac  <= 1'b0;
        end else begin
            state <= state_nxt;
            sel   <= sel_nxt;
            if (state == ST_IDLE && any_go) begin
                wr_addr <= {addr_hi, addr_lo};
                wr_dac  <= (addr_hi != '0);
                wr_data <= '0;
                wr_data[DW-1:1] <= msg_data[DW-1:1];
                wr_data[0] <= two_vec ? !pend[0] : msg_data[0];
            end
        end
    end

    always_comb begin
        wr_req = (state == ST_SEND);
        clr    = '0;
        if (state == ST_SEND && wr_ack) clr[sel] = 1'b1;
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_dac)));

    a_r7_dac_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_dac == (wr_addr[2*RW-1:RW] != '0)));

    a_r9_postq_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && msi_en && pend[0]) |=> (wr_req && !sel));
endmodule

// File: rtl/msi_irq_gen.sv
module msi_irq_gen
    import msi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        src_postq,
    input  logic        src_doorbell,
    input  logic        src_msg,
    output logic        wr_req,
    input  logic        wr_ack,
    output logic [63:0] wr_addr,
    output logic [31:0] wr_data,
    output logic        wr_dac,
    output logic        irq_n
);
    logic               msi_en, two_vec;
    logic [REG_W-1:0]   addr_lo, addr_hi;
    logic [MDATA_W-1:0] msg_data;
    logic [NUM_VEC-1:0] pend, clr;
    logic [NUM_SRC-1:0] src;

    assign src = {src_msg, src_doorbell, src_postq};

    msi_cfg_regs #(.RW(REG_W), .DW(MDATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_en(msi_en),
        .two_vec(two_vec), .addr_lo(addr_lo), .addr_hi(addr_hi), .msg_data(msg_data)
    );

    msi_pending #(.NS(NUM_SRC), .NV(NUM_VEC)) u_pend (
        .clk(clk), .rst_n(rst_n), .src(src), .msi_en(msi_en), .clr(clr), .pend(pend)
    );

    msi_issue_fsm #(.RW(REG_W), .DW(MDATA_W), .NV(NUM_VEC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pend(pend), .msi_en(msi_en), .two_vec(two_vec),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .msg_data(msg_data), .wr_ack(wr_ack),
        .clr(clr), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_dac(wr_dac)
    );

    assign irq_n = ~((|src) & ~msi_en);

    a_r10_msg_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> $past(msi_en));
endmodule

// File: tb/test_msi_irq_gen.sv
module test_msi_irq_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        src_postq = 1'b0, src_doorbell = 1'b0, src_msg = 1'b0;
    logic        wr_req, wr_ack = 1'b0, wr_dac, irq_n;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam logic [31:0] ADDR_LO = 32'hFEE0_1000;

    typedef struct packed {
        logic [2:0]  mme;
        logic [31:0] hi;
        logic [15:0] data;
        logic [1:0]  src;       // 0 post queue, 1 doorbell, 2 message
        logic [31:0] exp_data;
        logic        exp_dac;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 32'h0,         16'h4020, 2'd0, 32'h4020, 1'b0},  // R4
        '{3'd1, 32'h0,         16'h4020, 2'd1, 32'h4021, 1'b0},  // R4
        '{3'd1, 32'h1,         16'h4020, 2'd2, 32'h4021, 1'b1},  // R4 R7
        '{3'd0, 32'h0,         16'h4021, 2'd0, 32'h4021, 1'b0},  // R5
        '{3'd0, 32'h8000_0000, 16'h4020, 2'd2, 32'h4020, 1'b1},  // R5 R7
        '{3'd5, 32'h0,         16'h4021, 2'd0, 32'h4020, 1'b0},  // R6
        '{3'd7, 32'h0,         16'hBEE0, 2'd1, 32'hBEE1, 1'b0}   // R6
    };

    msi_irq_gen i_msi_irq_gen (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_postq(src_postq),
        .src_doorbell(src_doorbell), .src_msg(src_msg), .wr_req(wr_req),
        .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data), .wr_dac(wr_dac),
        .irq_n(irq_n)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [1:0] s);
        @(negedge clk);
        src_postq = (s == 2'd0); src_doorbell = (s == 2'd1); src_msg = (s == 2'd2);
        @(negedge clk);
        src_postq = 1'b0; src_doorbell = 1'b0; src_msg = 1'b0;
    endtask

    task automatic wait_req(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            if (wr_req) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic ack_and_check_drop(input string req);
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        chk(!wr_req, req, wr_req, 0);
    endtask

    task automatic quiet(input int n, input string req);
        bit any = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wr_req) any = 1'b1;
        end
        chk(!any, req, any, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        bit seen;
        logic [31:0] d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        reg_read(2'd0, rd); chk(rd == 32'h82, "R1 reset ctrl", rd, 32'h82);
        reg_read(2'd1, rd); chk(rd == 0, "R2 reset lo", rd, 0);
        reg_read(2'd2, rd); chk(rd == 0, "R2 reset hi", rd, 0);
        reg_read(2'd3, rd); chk(rd == 0, "R2 reset data", rd, 0);
        chk(irq_n && !wr_req, "R10 reset outputs", {irq_n, wr_req}, 2'b10);

        // register readback
        reg_write(2'd0, 32'hFFFF_FF51);
        reg_read(2'd0, rd); chk(rd == 32'hD3, "R1 ctrl readback", rd, 32'hD3);
        reg_write(2'd0, 32'h0);
        reg_write(2'd1, ADDR_LO);
        reg_read(2'd1, rd); chk(rd == ADDR_LO, "R2 lo readback", rd, ADDR_LO);
        reg_write(2'd2, 32'h1234_5678);
        reg_read(2'd2, rd); chk(rd == 32'h1234_5678, "R2 hi readback", rd, 32'h1234_5678);
        reg_write(2'd3, 32'hAAAA_5A5A);
        reg_read(2'd3, rd); chk(rd == 32'h5A5A, "R2 data readback", rd, 32'h5A5A);

        // vector table
        for (int k = 0; k < NV; k++) begin
            reg_write(2'd2, VECS[k].hi);
            reg_write(2'd3, {16'h0, VECS[k].data});
            reg_write(2'd0, {25'h0, VECS[k].mme, 4'h1});
            pulse(VECS[k].src);
            wait_req(seen);
            chk(seen, "R3 request issued", seen, 1);
            chk(wr_addr == {VECS[k].hi, ADDR_LO}, "R3 address", wr_addr, {VECS[k].hi, ADDR_LO});
            chk(wr_data == VECS[k].exp_data, "R4/R5/R6 data", wr_data, VECS[k].exp_data);
            chk(wr_dac == VECS[k].exp_dac, "R7 dac", wr_dac, VECS[k].exp_dac);
            ack_and_check_drop("R8 drop after ack");
        end

        // R8: hold without ack, fields stable even if registers change
        reg_write(2'd2, 32'h0);
        reg_write(2'd3, 32'h0100);
        reg_write(2'd0, 32'h11);
        pulse(2'd1);
        wait_req(seen);
        d0 = wr_data;
        reg_write(2'd3, 32'h0FF0);
        repeat (4) @(negedge clk);
        chk(wr_req && wr_data == d0 && wr_data == 32'h0101, "R8 hold", wr_data, 32'h0101);
        ack_and_check_drop("R8 drop");

        // R3: level held high does not repeat
        @(negedge clk); src_msg = 1'b1;
        wait_req(seen);
        chk(seen, "R3 held source first", seen, 1);
        ack_and_check_drop("R3 drop");
        quiet(8, "R3 no repeat while held");
        src_msg = 1'b0;

        // R9: simultaneous sources, post queue first
        reg_write(2'd3, 32'h0010);
        @(negedge clk);
        src_postq = 1'b1; src_doorbell = 1'b1;
        @(negedge clk);
        src_postq = 1'b0; src_doorbell = 1'b0;
        wait_req(seen);
        chk(seen && wr_data == 32'h10, "R9 first is post queue", wr_data, 32'h10);
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        wait_req(seen);
        chk(seen && wr_data == 32'h11, "R9 second is shared", wr_data, 32'h11);
        ack_and_check_drop("R9 drop");

        // R10: wired mode
        reg_write(2'd0, 32'h10);
        @(negedge clk); src_doorbell = 1'b1;
        #1 chk(!irq_n, "R10 wired asserted", irq_n, 0);
        quiet(10, "R10 no write when disabled");
        reg_write(2'd0, 32'h11);
        #1 chk(irq_n, "R10 wired off when enabled", irq_n, 1);
        quiet(6, "R10 no write on enable");
        src_doorbell = 1'b0;
        @(negedge clk);
        reg_write(2'd0, 32'h10);
        @(negedge clk);
        #1 chk(irq_n, "R10 wired idle", irq_n, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule